// File: doc/BRIEF.md
# Integer Decode and Execute Unit

This unit executes one 32-bit integer instruction per valid cycle. The instruction covers register-register and register-immediate operations. Its fields are split into an opcode, two source register numbers, a destination, a shift amount and a function code or a 16-bit immediate. The two source registers are read from an internal 32-entry register file. The second operand is formed as a register value, a sign-extended immediate or a zero-extended immediate, and the operation is computed. The result is written back at the same clock edge that registers the write-back outputs.

The write-back outputs report each committed write one cycle after the instruction is presented. They give the destination register number and the value written. An encoding the unit does not support raises a one-cycle illegal pulse and writes nothing. Register 0 always reads as zero. A write aimed at register 0 is dropped. Overflow never traps.

Top module: `alu_exec_unit`

## Requirements
- R1: With `valid_i` high at a rising edge, the unit decodes `instr_i` as opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0] and immediate [15:0]. After that edge `wb_en_o`, `wb_addr_o` and `wb_data_o` show the committed write, and the next instruction reads the updated register file.
- R2: Opcode 0x00 with function 0x20 or 0x21 writes Reg[rs]+Reg[rt] to rd. Function 0x22 or 0x23 writes Reg[rs]-Reg[rt]. The sum or difference wraps modulo 2^32 and never traps.
- R3: Opcode 0x00 with function 0x2A writes 1 to rd if Reg[rs] < Reg[rt] as signed numbers and 0 otherwise. Function 0x2B makes the same comparison unsigned.
- R4: Opcode 0x00 with functions 0x24, 0x25, 0x26 and 0x27 writes the bitwise and, or, xor and nor of Reg[rs] and Reg[rt] to rd.
- R5: Opcode 0x00 with functions 0x00, 0x02 and 0x03 shifts Reg[rt] by the shift-amount field and writes the result to rd. The three functions are left logical, right logical and right arithmetic. The arithmetic shift fills with the sign bit; the logical shifts fill with zeros.
- R6: Opcode 0x00 with functions 0x04, 0x06 and 0x07 shifts Reg[rt] in the same three ways. The shift amount is the low 5 bits of Reg[rs].
- R7: Opcodes 0x08 and 0x09 write Reg[rs] plus the sign-extended immediate to rt. Opcode 0x0A writes the signed comparison Reg[rs] < sext(imm) to rt as 1 or 0. Opcode 0x0B makes the same comparison unsigned, against the sign-extended immediate.
- R8: Opcodes 0x0C, 0x0D and 0x0E write the and, or and xor of Reg[rs] with the zero-extended immediate to rt. Opcode 0x0F writes the immediate in bits 31:16 and zeros in bits 15:0.
- R9: Register 0 reads as zero. An instruction whose destination is 0 writes nothing and leaves `wb_en_o` low.
- R10: Any other opcode, and any other function code under opcode 0x00, pulses `illegal_o` high for one cycle. It leaves `wb_en_o` low and changes no register.
- R11: With `valid_i` low at an edge, `wb_en_o` and `illegal_o` are low after that edge and no register changes.
- R12: While `rst_ni` is low, every register and every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| wb_en_o | output | 1 | A register was written at the last edge |
| wb_addr_o | output | 5 | Destination register of the last instruction |
| wb_data_o | output | 32 | Result of the last instruction |
| illegal_o | output | 1 | Last instruction was an unsupported encoding |

## Verification
The assertions assume that `valid_i` and `instr_i` are stable and free of X across each rising edge. They also assume that `rst_ni` is released between edges. The bench drives every input on the falling edge and samples the outputs on the following falling edge, so both assumptions hold. The sweep covers all 64 opcodes and all 64 function codes. Operands are loaded only through legal upper-immediate and or-immediate instructions, so the register file never holds a value the bench cannot model.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int INSTR_W = 32;
  localparam int FIELD_W = 6;
  localparam int IMM_W   = 16;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {B_REG, B_SEXT, B_ZEXT} b_sel_e;

  typedef struct packed {
    alu_op_e    op;
    b_sel_e     b_sel;
    logic       sh_var;
    logic [4:0] dst;
    logic       legal;
  } dec_t;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ADIU = 6'h09;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_SLIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LUI  = 6'h0F;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [5:0] opc, fn;
  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];

  always_comb begin
    dec_o        = '0;
    dec_o.op     = ALU_ADD;
    dec_o.b_sel  = B_REG;
    dec_o.legal  = 1'b1;
    dec_o.dst    = instr_i[20:16];
    if (opc == OPC_REG) begin
      dec_o.dst = instr_i[15:11];
      unique case (fn)
        6'h20, 6'h21: dec_o.op = ALU_ADD;
        6'h22, 6'h23: dec_o.op = ALU_SUB;
        6'h2A:        dec_o.op = ALU_SLT;
        6'h2B:        dec_o.op = ALU_SLTU;
        6'h24:        dec_o.op = ALU_AND;
        6'h25:        dec_o.op = ALU_OR;
        6'h26:        dec_o.op = ALU_XOR;
        6'h27:        dec_o.op = ALU_NOR;
        6'h00:        dec_o.op = ALU_SLL;
        6'h02:        dec_o.op = ALU_SRL;
        6'h03:        dec_o.op = ALU_SRA;
        6'h04: begin  dec_o.op = ALU_SLL; dec_o.sh_var = 1'b1; end
        6'h06: begin  dec_o.op = ALU_SRL; dec_o.sh_var = 1'b1; end
        6'h07: begin  dec_o.op = ALU_SRA; dec_o.sh_var = 1'b1; end
        default:      dec_o.legal = 1'b0;
      endcase
    end else begin
      unique case (opc)
        OPC_ADDI, OPC_ADIU: begin dec_o.op = ALU_ADD;  dec_o.b_sel = B_SEXT; end
        OPC_SLTI:           begin dec_o.op = ALU_SLT;  dec_o.b_sel = B_SEXT; end
        OPC_SLIU:           begin dec_o.op = ALU_SLTU; dec_o.b_sel = B_SEXT; end
        OPC_ANDI:           begin dec_o.op = ALU_AND;  dec_o.b_sel = B_ZEXT; end
        OPC_ORI:            begin dec_o.op = ALU_OR;   dec_o.b_sel = B_ZEXT; end
        OPC_XORI:           begin dec_o.op = ALU_XOR;  dec_o.b_sel = B_ZEXT; end
        OPC_LUI:            begin dec_o.op = ALU_LUI;  dec_o.b_sel = B_ZEXT; end
        default:            dec_o.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_SLT:  y_o = DATA_W'($signed(a_i) < $signed(b_i));
      ALU_SLTU: y_o = DATA_W'(a_i < b_i);
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_NOR:  y_o = ~(a_i | b_i);
      ALU_SLL:  y_o = b_i << sh_i;
      ALU_SRL:  y_o = b_i >> sh_i;
      ALU_SRA:  y_o = DATA_W'($signed(b_i) >>> sh_i);
      ALU_LUI:  y_o = b_i << HALF;
      default:  y_o = '0;
    endcase
  end

  always_comb begin
    // R5
    if (op_i == ALU_SRA) sra_sign_chk: assert (y_o[DATA_W-1] == b_i[DATA_W-1]);
    // R3
    if (op_i inside {ALU_SLT, ALU_SLTU}) slt_bool_chk: assert (y_o[DATA_W-1:1] == '0);
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra_i,
  input  logic [AW-1:0]     rb_i,
  output logic [DATA_W-1:0] qa_o,
  output logic [DATA_W-1:0] qb_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          regs[g] <= '0;
        else if (we_i && wa_i == AW'(g))      regs[g] <= wd_i;
      end
    end
  end

  assign qa_o = regs[ra_i];
  assign qb_o = regs[rb_i];

  // R1
  wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wa_i != '0 |=> regs[$past(wa_i)] == $past(wd_i));
  // R9
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_i == '0 |-> qa_o == '0);
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int AW    = $clog2(REG_N),
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rs_q, rt_q, b_op, res;
  logic [SH_W-1:0]   sh;
  logic [IMM_W-1:0]  imm;
  logic              we;

  assign imm = instr_i[15:0];

  exu_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  exu_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra_i(AW'(instr_i[25:21])), .rb_i(AW'(instr_i[20:16])),
    .qa_o(rs_q), .qb_o(rt_q),
    .we_i(we), .wa_i(AW'(dec.dst)), .wd_i(res)
  );

  always_comb begin
    unique case (dec.b_sel)
      B_SEXT:  b_op = DATA_W'($signed(imm));
      B_ZEXT:  b_op = DATA_W'(imm);
      default: b_op = rt_q;
    endcase
  end

  assign sh = dec.sh_var ? rs_q[SH_W-1:0] : SH_W'(instr_i[10:6]);

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(dec.op), .a_i(rs_q), .b_i(b_op), .sh_i(sh), .y_o(res)
  );

  assign we = valid_i && dec.legal && dec.dst != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_addr_o <= '0;
      wb_data_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      wb_en_o   <= we;
      illegal_o <= valid_i && !dec.legal;
      if (valid_i) begin
        wb_addr_o <= AW'(dec.dst);
        wb_data_o <= res;
      end
    end
  end

  // R10
  illegal_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);
  // R10
  illegal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o && !valid_i |=> !illegal_o);
  // R9
  wb_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_addr_o != '0);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wb_en_o && !illegal_o);
endmodule

// File: tb/alu_exec_unit_tb.sv
module alu_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic        wb_en, illegal;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [32];
  logic [31:0] seed = 32'h1234_5679;

  always #5 clk = ~clk;

  alu_exec_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .illegal_o(illegal)
  );

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sa);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sa), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, output bit legal, output logic [4:0] dst,
                       output logic [31:0] v, output string tag);
    logic [5:0] op, fn;
    logic [31:0] a, b, se, ze;
    logic [4:0] sa;
    op = ins[31:26]; fn = ins[5:0];
    a = mdl[ins[25:21]]; b = mdl[ins[20:16]];
    se = {{16{ins[15]}}, ins[15:0]}; ze = {16'h0, ins[15:0]};
    sa = ins[10:6];
    legal = 1; v = 0; tag = "R10";
    dst = (op == 0) ? ins[15:11] : ins[20:16];
    if (op == 0) begin
      case (fn)
        6'h20, 6'h21: begin v = a + b; tag = "R2"; end
        6'h22, 6'h23: begin v = a - b; tag = "R2"; end
        6'h2A: begin v = {31'b0, $signed(a) < $signed(b)}; tag = "R3"; end
        6'h2B: begin v = {31'b0, a < b}; tag = "R3"; end
        6'h24: begin v = a & b; tag = "R4"; end
        6'h25: begin v = a | b; tag = "R4"; end
        6'h26: begin v = a ^ b; tag = "R4"; end
        6'h27: begin v = ~(a | b); tag = "R4"; end
        6'h00: begin v = b << sa; tag = "R5"; end
        6'h02: begin v = b >> sa; tag = "R5"; end
        6'h03: begin v = $signed(b) >>> sa; tag = "R5"; end
        6'h04: begin v = b << a[4:0]; tag = "R6"; end
        6'h06: begin v = b >> a[4:0]; tag = "R6"; end
        6'h07: begin v = $signed(b) >>> a[4:0]; tag = "R6"; end
        default: legal = 0;
      endcase
    end else begin
      case (op)
        6'h08, 6'h09: begin v = a + se; tag = "R7"; end
        6'h0A: begin v = {31'b0, $signed(a) < $signed(se)}; tag = "R7"; end
        6'h0B: begin v = {31'b0, a < se}; tag = "R7"; end
        6'h0C: begin v = a & ze; tag = "R8"; end
        6'h0D: begin v = a | ze; tag = "R8"; end
        6'h0E: begin v = a ^ ze; tag = "R8"; end
        6'h0F: begin v = {ins[15:0], 16'h0}; tag = "R8"; end
        default: legal = 0;
      endcase
    end
    if (legal && dst == 0) tag = "R9";
  endtask

  // drive on falling edge, sample outputs on the next falling edge (R1)
  task automatic exec(input logic [31:0] ins);
    bit legal; logic [4:0] dst; logic [31:0] v; string tag; bit exp_en;
    model(ins, legal, dst, v, tag);
    exp_en = legal && dst != 0;
    @(negedge clk); valid = 1'b1; instr = ins;
    @(negedge clk); valid = 1'b0; instr = nxt();
    chk(tag, wb_en == exp_en && illegal == !legal, {wb_en, illegal}, {exp_en, !legal});
    if (exp_en)
      chk(tag, wb_addr == dst && wb_data == v, {wb_addr, wb_data}, {dst, v});
    if (exp_en) mdl[dst] = v;
  endtask

  task automatic load_reg(int r, logic [31:0] val);
    exec(enc_i(6'h0F, 0, r, val[31:16]));
    exec(enc_i(6'h0D, r, r, val[15:0]));
  endtask

  function automatic logic [31:0] pat(int k);
    case (k % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h0000_001F;
      default: return nxt();
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R12: outputs clear in reset
    chk("R12", wb_en == 0 && illegal == 0 && wb_addr == 0 && wb_data == 0,
        {wb_en, illegal, wb_addr, wb_data}, 64'h0);
    rst_n = 1'b1;
    // R12: every register reads zero
    for (int r = 1; r < 32; r++) begin
      exec(enc_r(6'h25, r, 0, 1, 0));
      chk("R12", wb_data == 0, wb_data, 0);
    end

    // R9: writes to register 0 dropped
    exec(enc_i(6'h08, 0, 0, 16'h007B));
    exec(enc_r(6'h25, 0, 0, 3, 0));
    chk("R9", wb_data == 0, wb_data, 0);

    // R11: idle cycle with a legal-looking word leaves state unchanged
    load_reg(5, 32'hCAFE_0001);
    @(negedge clk); instr = enc_i(6'h08, 5, 5, 16'h0010); valid = 1'b0;
    @(negedge clk);
    chk("R11", wb_en == 0 && illegal == 0, {wb_en, illegal}, 0);
    exec(enc_r(6'h25, 5, 0, 6, 0));
    chk("R11", wb_data == 32'hCAFE_0001, wb_data, 32'hCAFE_0001);

    // R6: amount uses only low 5 bits of rs
    load_reg(1, 32'h0000_0124);
    load_reg(2, 32'h0000_0003);
    exec(enc_r(6'h04, 1, 2, 3, 0));
    chk("R6", wb_data == 32'h30, wb_data, 32'h30);

    // sweep all opcodes and all function codes
    for (int op = 0; op < 64; op++) begin
      int reps = (op == 0) ? 64 * 6 : 6;
      for (int k = 0; k < reps; k++) begin
        logic [31:0] w;
        if (k % 6 == 0)
          for (int r = 1; r < 8; r++) load_reg(r, pat(r + k + op));
        w = nxt();
        if (op == 0) w = enc_r(k / 6, w[2:0], w[5:3], w[8:6], w[14:10]);
        else         w = enc_i(op, w[2:0], w[5:3], w[31:16]);
        exec(w);
      end
    end

    // R1: back-to-back results chain through the register file
    load_reg(1, 32'd6);
    exec(enc_r(6'h20, 1, 1, 2, 0));
    exec(enc_r(6'h20, 2, 2, 2, 0));
    exec(enc_r(6'h20, 2, 2, 2, 0));
    exec(enc_r(6'h22, 2, 1, 1, 0));
    chk("R1", wb_data == 32'd42 && wb_addr == 1, {wb_addr, wb_data}, {5'd1, 32'd42});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule